// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a small finite state machine that sells one item priced at twenty cents. It watches three coin strobes, one per coin kind (nickel, dime, quarter), and keeps a running credit between coins. Credit is counted in nickel units, so the only credit values it can hold are 0, 5, 10 and 15 cents. These are stored in two D flip-flops as 00, 01, 10 and 11 (nickel units in binary).

When a coin brings the total to twenty cents or more, the controller asserts its vend output during the same cycle in which that coin is presented. In that cycle it also reports the overshoot as a count of nickels, and on the next edge it drops back to zero credit for the next customer. The next state and the outputs are a flat two-level function of the present state and the decoded coin. A cycle that has no strobe, or more than one strobe, is treated as no event.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high on a rising edge, the credit is forced to zero. While `rst` is high, `vend_o` is 0 and `change_o` is 0, even when a coin strobe is high.
- R2: A nickel strobe adds 1 nickel unit (5 cents), a dime adds 2 units (10 cents) and a quarter adds 5 units (25 cents) to the credit.
- R3: `vend_o` is 1 in the cycle in which exactly one coin strobe is high and the credit plus that coin is at least 4 units (20 cents). This output is combinational from that cycle's strobes.
- R4: In a vend cycle, `change_o` equals (credit + coin − 4) as an unsigned 3-bit nickel count, with a range of 0 to 4. Outside a vend cycle, `change_o` is 0.
- R5: After a vend cycle the credit is zero.
- R6: A single coin that leaves the total below 4 units gives no vend and zero change, and is added to the credit.
- R7: A cycle in which two or three strobes are high leaves the credit unchanged and gives `vend_o` = 0 and `change_o` = 0.
- R8: A cycle with no strobe leaves the credit unchanged and gives `vend_o` = 0, so a vend lasts exactly one cycle per threshold-crossing coin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel_i | input | 1 | Nickel inserted this cycle |
| coin_dime_i | input | 1 | Dime inserted this cycle |
| coin_quarter_i | input | 1 | Quarter inserted this cycle |
| vend_o | output | 1 | Dispense pulse for the threshold-crossing coin |
| change_o | output | 3 | Change owed in nickels, valid while vend_o is high |

## Verification
The assertions take the coin strobes to be synchronous levels that are stable at each rising edge. They treat any cycle whose strobe count is not exactly one as a non-event, so the rules on credit growth and credit hold are stated separately for one-strobe and other cycles. The stimulus changes the strobes only on falling edges and samples the outputs shortly afterwards. It deliberately drives double and triple strobes and strobes during reset, so these assumptions are exercised as part of normal operation rather than excluded. Because the credit is internal, its value after an ignored event is shown by a following coin whose vend and change depend on the credit it found.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [1:0] {
        COIN_NONE    = 2'd0,
        COIN_NICKEL  = 2'd1,
        COIN_DIME    = 2'd2,
        COIN_QUARTER = 2'd3
    } coin_kind_e;

    localparam int NICKEL_UNITS  = 1;
    localparam int DIME_UNITS    = 2;
    localparam int QUARTER_UNITS = 5;
    localparam int UNIT_W        = $clog2(QUARTER_UNITS + 1);

    typedef struct packed {
        logic       valid;
        coin_kind_e kind;
    } coin_evt_t;

    function automatic logic [UNIT_W-1:0] coin_units(input coin_kind_e k);
        case (k)
            COIN_NICKEL:  coin_units = UNIT_W'(NICKEL_UNITS);
            COIN_DIME:    coin_units = UNIT_W'(DIME_UNITS);
            COIN_QUARTER: coin_units = UNIT_W'(QUARTER_UNITS);
            default:      coin_units = '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic      nickel,
    input  logic      dime,
    input  logic      quarter,
    output coin_evt_t evt
);
    logic [1:0] strobe_cnt;

    always_comb begin
        strobe_cnt = 2'(nickel) + 2'(dime) + 2'(quarter);
        evt.valid  = (strobe_cnt == 2'd1);
        if (!evt.valid)   evt.kind = COIN_NONE;
        else if (nickel)  evt.kind = COIN_NICKEL;
        else if (dime)    evt.kind = COIN_DIME;
        else              evt.kind = COIN_QUARTER;
    end
endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS = 4,
    parameter int CRED_W      = 2,
    parameter int CHG_W       = 3
) (
    input  logic [CRED_W-1:0] credit_q,
    input  coin_evt_t         evt,
    output logic [CRED_W-1:0] credit_d,
    output logic              vend,
    output logic [CHG_W-1:0]  change
);
    localparam int SUM_W = $clog2(PRICE_UNITS + QUARTER_UNITS);

    logic [SUM_W-1:0] total;
    logic             reached;

    always_comb begin
        total   = SUM_W'(credit_q) + SUM_W'(coin_units(evt.kind));
        reached = total >= SUM_W'(PRICE_UNITS);
        if (!evt.valid) begin
            credit_d = credit_q;
            vend     = 1'b0;
            change   = '0;
        end else if (reached) begin
            credit_d = '0;
            vend     = 1'b1;
            change   = CHG_W'(total - SUM_W'(PRICE_UNITS));
        end else begin
            credit_d = CRED_W'(total);
            vend     = 1'b0;
            change   = '0;
        end
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic coin_nickel_i,
    input  logic coin_dime_i,
    input  logic coin_quarter_i,
    output logic vend_o,
    output logic [$clog2(QUARTER_UNITS)-1:0] change_o
);
    localparam int CRED_W = $clog2(PRICE_UNITS);
    localparam int CHG_W  = $clog2(QUARTER_UNITS);

    coin_evt_t         evt;
    logic [CRED_W-1:0] credit_q, credit_d;
    logic              vend_raw;
    logic [CHG_W-1:0]  change_raw;

    vend_coin_decode u_decode (
        .nickel  (coin_nickel_i),
        .dime    (coin_dime_i),
        .quarter (coin_quarter_i),
        .evt     (evt)
    );

    vend_step_logic #(
        .PRICE_UNITS (PRICE_UNITS),
        .CRED_W      (CRED_W),
        .CHG_W       (CHG_W)
    ) u_step (
        .credit_q (credit_q),
        .evt      (evt),
        .credit_d (credit_d),
        .vend     (vend_raw),
        .change   (change_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) credit_q <= '0;
        else     credit_q <= credit_d;
    end

    assign vend_o   = vend_raw & ~rst;
    assign change_o = rst ? '0 : change_raw;

    logic [1:0] strobes_n;
    assign strobes_n = 2'(coin_nickel_i) + 2'(coin_dime_i) + 2'(coin_quarter_i);

    assert_vend_clears_R5: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> (credit_q == '0));

    assert_change_needs_vend_R4: assert property (@(posedge clk) disable iff (rst)
        (change_o != '0) |-> vend_o);

    assert_change_range_R4: assert property (@(posedge clk) disable iff (rst)
        change_o <= CHG_W'(QUARTER_UNITS - 1));

    assert_bad_strobe_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (strobes_n > 2'd1) |=> (credit_q == $past(credit_q)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (strobes_n == 2'd0) |=> (credit_q == $past(credit_q)));

    assert_no_event_no_vend_R7: assert property (@(posedge clk) disable iff (rst)
        (strobes_n != 2'd1) |-> (!vend_o && change_o == '0));

    assert_accumulate_R6: assert property (@(posedge clk) disable iff (rst)
        (strobes_n == 2'd1 && !vend_o) |=> (credit_q > $past(credit_q)));
endmodule

// File: tb/test_coin_vend_ctrl.sv
`timescale 1ns/1ps
module test_coin_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       n = 1'b0, d = 1'b0, q = 1'b0;
    logic       vend_o;
    logic [2:0] change_o;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    coin_vend_ctrl i_coin_vend_ctrl (
        .clk            (clk),
        .rst            (rst),
        .coin_nickel_i  (n),
        .coin_dime_i    (d),
        .coin_quarter_i (q),
        .vend_o         (vend_o),
        .change_o       (change_o)
    );

    task automatic check(input logic ev, input logic [2:0] ec, input string tag);
        tests++;
        if (vend_o !== ev || change_o !== ec) begin
            fails++;
            $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
                     tag, vend_o, change_o, ev, ec);
        end
    endtask

    task automatic apply(input logic an, input logic ad, input logic aq,
                         input logic ev, input logic [2:0] ec, input string tag);
        @(negedge clk);
        n = an; d = ad; q = aq;
        #1;
        check(ev, ec, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        q = 1'b1;
        #1; check(1'b0, 3'd0, "R1 quarter during reset");
        @(negedge clk);
        rst = 1'b0; q = 1'b0;
        #1; check(1'b0, 3'd0, "R1 idle after reset");
        apply(0, 1, 0, 0, 0, "R1 first dime from zero");
        apply(0, 1, 0, 1, 0, "R1 second dime vends exact");
    endtask

    task automatic t_overshoot();
        apply(1, 0, 0, 0, 0, "R6 nickel 5");
        apply(1, 0, 0, 0, 0, "R6 nickel 10");
        apply(1, 0, 0, 0, 0, "R6 nickel 15");
        apply(0, 0, 1, 1, 4, "R4 quarter on 15 gives 4 nickels");
        apply(0, 0, 0, 0, 0, "R8 vend lasts one cycle");
        apply(0, 0, 1, 1, 1, "R5 credit zero after vend, quarter alone");
    endtask

    task automatic t_invalid();
        apply(1, 0, 0, 0, 0, "R6 nickel 5");
        apply(1, 0, 0, 0, 0, "R6 nickel 10");
        apply(1, 0, 0, 0, 0, "R6 nickel 15");
        apply(1, 1, 0, 0, 0, "R7 nickel+dime ignored");
        apply(0, 1, 1, 0, 0, "R7 dime+quarter ignored");
        apply(1, 1, 1, 0, 0, "R7 all strobes ignored");
        apply(1, 0, 0, 1, 0, "R7 credit still 15");
    endtask

    task automatic t_idle();
        apply(0, 1, 0, 0, 0, "R6 dime 10");
        apply(0, 0, 0, 0, 0, "R8 idle");
        apply(0, 0, 0, 0, 0, "R8 idle");
        apply(0, 0, 0, 0, 0, "R8 idle");
        apply(0, 1, 0, 1, 0, "R8 credit held at 10");
    endtask

    task automatic t_midreset();
        apply(1, 0, 0, 0, 0, "R6 nickel 5");
        apply(1, 0, 0, 0, 0, "R6 nickel 10");
        apply(1, 0, 0, 0, 0, "R6 nickel 15");
        @(negedge clk);
        rst = 1'b1; n = 1'b0; d = 1'b1;
        #1; check(1'b0, 3'd0, "R1 dime on 15 under reset");
        @(negedge clk);
        rst = 1'b0; d = 1'b0;
        apply(0, 1, 0, 0, 0, "R1 credit cleared by reset");
        apply(0, 1, 0, 1, 0, "R1 vend after two dimes");
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) begin
                int u, tot;
                u   = (k == 0) ? 1 : (k == 1) ? 2 : 5;
                tot = c + u;
                for (int i = 0; i < c; i++)
                    apply(1, 0, 0, 0, 0, "R2 sweep preload");
                if (tot >= 4) begin
                    apply(k == 0, k == 1, k == 2, 1, 3'(tot - 4), "R3 sweep crossing");
                end else begin
                    apply(k == 0, k == 1, k == 2, 0, 0, "R2 sweep below price");
                    apply(0, 0, 1, 1, 3'(tot + 5 - 4), "R2 sweep quarter finish");
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_overshoot();
        t_invalid();
        t_idle();
        t_midreset();
        t_sweep();
        apply(0, 0, 0, 0, 0, "R8 final idle");
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule